// File: doc/BRIEF.md
# Double-Indexed DMA Address Generator

This block produces the address of each element for one side of a DMA channel, either the read side or the write side. A start pulse captures the configuration. The first address then appears on `addr`, and each advance pulse moves `addr` to the next element. The element count sets how many elements make up a frame, and the frame count sets how many frames make up a block. Two flags mark the last element of a frame and the last element of the block.

There are three addressing modes. In constant mode the address never moves. In increment mode the address grows by the element size. In double-indexed mode two signed indices are added: one between elements of a frame and one between frames. The double-indexed mode lets a transfer sweep a peripheral's fixed address window again and again. The element index is set to 1 so that each frame walks the window byte by byte. The frame index is set to minus one less than the window size, which returns the address to the window base after the last byte.

At start the block also captures two settings from the window size. The first is a burst length: the largest of 64, 32 or 16 bytes that divides the window. The second is a write-posting mode for the device-write side.

Top module: `dma_idx_addr_gen`

## Requirements
- R1: After a synchronous reset, the outputs are as follows: `busy`=0, `addr`=0, both end flags 0, `burstSel`=0, `packEn`=0 and `writeMode`=1.
- R2: A start with nonzero element and frame counts makes `busy`=1 on the next cycle, with `addr` equal to the start address.
- R3: A start with a zero element count or a zero frame count leaves the block idle (`busy`=0), including when the block was busy before. `addr` is not reloaded.
- R4: Mode code 0 (constant): `addr` stays unchanged on every advance.
- R5: Mode code 1 (increment): every advance adds the element size in bytes, 2^`elemSizeSel`, and this includes advances across frame boundaries.
- R6: Mode code 2 (double-indexed): an advance within a frame adds element bytes + `elemIdx` − 1.
- R7: Mode code 2: an advance from the last element of a frame adds element bytes + `frameIdx` − 1. The index is signed and the sum wraps modulo 2^ADDR_W. With an element index of 1 and a frame index of −(W−1), each frame rewinds to the window base.
- R8: `addr` changes only on a cycle with `advance`=1 while busy, or on a start. An advance while idle has no effect.
- R9: `endOfFrame` is 1 while the current element is the last of its frame. `endOfBlock` is 1 while it is the last element of the last frame. An advance there clears `busy` and holds `addr`.
- R10: On an accepted start, `burstSel` is set from the window size. It is 3 (64 B) if the window is a nonzero multiple of 64, otherwise 2 (32 B) for a multiple of 32, otherwise 1 (16 B) for a multiple of 16, otherwise 0 (single access). `packEn` is 1 exactly when `burstSel` is nonzero.
- R11: On an accepted start, `writeMode` is set to 2 (posted except the last write, which is non-posted) when the window is nonzero and `devWrite`=1. Otherwise it is set to 1 (posted). Code 0 means non-posted.
- R12: Mode code 3 behaves as constant addressing.
- R13: A start while busy restarts the block from the new start address, with the element and frame positions cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture configuration and begin a block |
| advance | input | 1 | Move to the next element |
| mode | input | 2 | 0 constant, 1 increment, 2 double-indexed, 3 constant |
| elemSizeSel | input | 2 | Element size is 2^value bytes |
| elemCount | input | CNT_W | Elements per frame |
| frameCount | input | CNT_W | Frames per block |
| elemIdx | input | IDX_W | Signed element index |
| frameIdx | input | IDX_W | Signed frame index |
| startAddr | input | ADDR_W | First element address |
| windowSize | input | WIN_W | Device window size in bytes, 0 for none |
| devWrite | input | 1 | This side writes to the device |
| addr | output | ADDR_W | Current element address |
| busy | output | 1 | A block is in progress |
| endOfFrame | output | 1 | Current element is last of its frame |
| endOfBlock | output | 1 | Current element is last of the block |
| burstSel | output | 2 | Burst code captured at start |
| packEn | output | 1 | Packed access enabled |
| writeMode | output | 2 | Write-posting code captured at start |

## Verification
The assertions assume that `start` and `advance` are single-cycle strobes sampled on the rising edge. They also assume that the configuration inputs are stable on the cycle `start` is high. They place no requirement on `advance` while the block is idle, because that case is defined as having no effect. The stimulus drives every input on the falling edge, holds the configuration around each start, and uses small counts. Wrap-around and negative indices are reached through chosen start addresses rather than through long runs.

// File: rtl/dma_idx_pkg.sv
package dma_idx_pkg;

  // Address-mode codes (R4, R5, R6, R12)
  typedef enum logic [1:0] {
    AM_CONST = 2'd0,
    AM_INC   = 2'd1,
    AM_DBL   = 2'd2,
    AM_RSV   = 2'd3
  } addrMode_e;

  // Write-posting codes (R11)
  typedef enum logic [1:0] {
    WM_NONPOST = 2'd0,
    WM_POST    = 2'd1,
    WM_LASTNP  = 2'd2
  } writeMode_e;

  localparam int BURST_LEVELS = 3;
  localparam int BSEL_W       = $clog2(BURST_LEVELS + 1);

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;
    logic stepElem;
    logic stepFrame;
  } stepCtl_t;

endpackage

// File: rtl/dma_idx_ctrl.sv
module dma_idx_ctrl
  import dma_idx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             advance,
  input  logic [CNT_W-1:0] elemCount,
  input  logic [CNT_W-1:0] frameCount,
  output stepCtl_t         ctl,
  output logic             busy,
  output logic             endOfFrame,
  output logic             endOfBlock
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] elemPos, framePos;
  logic [CNT_W-1:0] elemLim, frameLim;
  logic             countsOk, stepping, elemLast, frameLast;

  assign countsOk  = (elemCount != '0) && (frameCount != '0);
  assign stepping  = busy && advance && !start;
  assign elemLast  = (elemPos == elemLim - ONE);
  assign frameLast = (framePos == frameLim - ONE);

  assign ctl.load      = start && countsOk;
  assign ctl.stepElem  = stepping && !elemLast;
  assign ctl.stepFrame = stepping && elemLast && !frameLast;

  assign endOfFrame = busy && elemLast;
  assign endOfBlock = busy && elemLast && frameLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      elemPos  <= '0;
      framePos <= '0;
      elemLim  <= '0;
      frameLim <= '0;
    end else if (start) begin
      if (countsOk) begin
        busy     <= 1'b1;
        elemPos  <= '0;
        framePos <= '0;
        elemLim  <= elemCount;
        frameLim <= frameCount;
      end else begin
        busy <= 1'b0;
      end
    end else if (stepping) begin
      if (elemLast) begin
        elemPos <= '0;
        if (frameLast) begin
          busy <= 1'b0;
        end else begin
          framePos <= framePos + ONE;
        end
      end else begin
        elemPos <= elemPos + ONE;
      end
    end
  end

endmodule

// File: rtl/dma_idx_dpath.sv
module dma_idx_dpath
  import dma_idx_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int IDX_W          = 16,
  parameter int WIN_W          = 16,
  parameter int BURST_MIN_LOG2 = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  stepCtl_t                ctl,
  input  logic [1:0]              mode,
  input  logic [1:0]              elemSizeSel,
  input  logic signed [IDX_W-1:0] elemIdx,
  input  logic signed [IDX_W-1:0] frameIdx,
  input  logic [ADDR_W-1:0]       startAddr,
  input  logic [WIN_W-1:0]        windowSize,
  input  logic                    devWrite,
  output logic [ADDR_W-1:0]       addr,
  output logic [BSEL_W-1:0]       burstSel,
  output logic                    packEn,
  output logic [1:0]              writeMode
);

  logic [ADDR_W-1:0] elemBytes, eiExt, fiExt;
  logic [ADDR_W-1:0] stepInNext, stepFrNext;
  logic [ADDR_W-1:0] stepIn, stepFr;
  logic [BURST_LEVELS-1:0] fits;
  logic [BSEL_W-1:0] burstNext;
  logic [1:0]        wmNext;

  assign elemBytes = ADDR_W'(1) << elemSizeSel;
  assign eiExt     = ADDR_W'(elemIdx);
  assign fiExt     = ADDR_W'(frameIdx);

  // Step values are worked out once at start; the per-element path is a single add
  always_comb begin
    unique case (addrMode_e'(mode))
      AM_INC: begin
        stepInNext = elemBytes;
        stepFrNext = elemBytes;
      end
      AM_DBL: begin
        stepInNext = elemBytes + eiExt - ADDR_W'(1);
        stepFrNext = elemBytes + fiExt - ADDR_W'(1);
      end
      default: begin
        stepInNext = '0;
        stepFrNext = '0;
      end
    endcase
  end

  // A window fits a burst level when its low bits are clear
  for (genvar g = 0; g < BURST_LEVELS; g++) begin : g_fit
    assign fits[g] = (windowSize != '0) &&
                     (windowSize[BURST_MIN_LOG2+g-1:0] == '0);
  end

  // Largest fitting level wins
  always_comb begin
    burstNext = '0;
    for (int k = 0; k < BURST_LEVELS; k++) begin
      if (fits[k]) burstNext = BSEL_W'(k + 1);
    end
  end

  assign wmNext = ((windowSize != '0) && devWrite) ? WM_LASTNP : WM_POST;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr      <= '0;
      stepIn    <= '0;
      stepFr    <= '0;
      burstSel  <= '0;
      writeMode <= WM_POST;
    end else if (ctl.load) begin
      addr      <= startAddr;
      stepIn    <= stepInNext;
      stepFr    <= stepFrNext;
      burstSel  <= burstNext;
      writeMode <= wmNext;
    end else if (ctl.stepFrame) begin
      addr <= addr + stepFr;
    end else if (ctl.stepElem) begin
      addr <= addr + stepIn;
    end
  end

  assign packEn = (burstSel != '0);

endmodule

// File: rtl/dma_idx_addr_gen.sv
module dma_idx_addr_gen
  import dma_idx_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int CNT_W          = 16,
  parameter int IDX_W          = 16,
  parameter int WIN_W          = 16,
  parameter int BURST_MIN_LOG2 = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    advance,
  input  logic [1:0]              mode,
  input  logic [1:0]              elemSizeSel,
  input  logic [CNT_W-1:0]        elemCount,
  input  logic [CNT_W-1:0]        frameCount,
  input  logic signed [IDX_W-1:0] elemIdx,
  input  logic signed [IDX_W-1:0] frameIdx,
  input  logic [ADDR_W-1:0]       startAddr,
  input  logic [WIN_W-1:0]        windowSize,
  input  logic                    devWrite,
  output logic [ADDR_W-1:0]       addr,
  output logic                    busy,
  output logic                    endOfFrame,
  output logic                    endOfBlock,
  output logic [1:0]              burstSel,
  output logic                    packEn,
  output logic [1:0]              writeMode
);

  stepCtl_t ctl;

  dma_idx_ctrl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .advance   (advance),
    .elemCount (elemCount),
    .frameCount(frameCount),
    .ctl       (ctl),
    .busy      (busy),
    .endOfFrame(endOfFrame),
    .endOfBlock(endOfBlock)
  );

  dma_idx_dpath #(
    .ADDR_W        (ADDR_W),
    .IDX_W         (IDX_W),
    .WIN_W         (WIN_W),
    .BURST_MIN_LOG2(BURST_MIN_LOG2)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .mode       (mode),
    .elemSizeSel(elemSizeSel),
    .elemIdx    (elemIdx),
    .frameIdx   (frameIdx),
    .startAddr  (startAddr),
    .windowSize (windowSize),
    .devWrite   (devWrite),
    .addr       (addr),
    .burstSel   (burstSel),
    .packEn     (packEn),
    .writeMode  (writeMode)
  );

endmodule

// File: rtl/dma_idx_chk.sv
module dma_idx_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              advance,
  input logic [CNT_W-1:0]  elemCount,
  input logic [CNT_W-1:0]  frameCount,
  input logic [ADDR_W-1:0] startAddr,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              endOfBlock,
  input logic [1:0]        burstSel,
  input logic [1:0]        writeMode
);

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (start && elemCount != '0 && frameCount != '0) |=> (busy && addr == $past(startAddr)));

  // R3
  zero_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (elemCount == '0 || frameCount == '0)) |=> !busy);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(addr));

  // R8
  no_advance_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !advance && !start) |=> $stable(addr));

  // R9
  block_end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && endOfBlock && advance && !start) |=> (!busy && $stable(addr)));

  // R10
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(burstSel));

  // R11
  wmode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(writeMode));

endmodule

bind dma_idx_addr_gen dma_idx_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .advance   (advance),
  .elemCount (elemCount),
  .frameCount(frameCount),
  .startAddr (startAddr),
  .addr      (addr),
  .busy      (busy),
  .endOfBlock(endOfBlock),
  .burstSel  (burstSel),
  .writeMode (writeMode)
);

// File: tb/dma_idx_addr_gen_tb.sv
module dma_idx_addr_gen_tb;

  logic clk = 1'b0;
  logic rst, start, advance, devWrite;
  logic [1:0]  mode, elemSizeSel;
  logic [15:0] elemCount, frameCount, windowSize;
  logic signed [15:0] elemIdx, frameIdx;
  logic [31:0] startAddr, addr;
  logic busy, endOfFrame, endOfBlock, packEn;
  logic [1:0] burstSel, writeMode;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  dma_idx_addr_gen u_dut (
    .clk(clk), .rst(rst), .start(start), .advance(advance), .mode(mode),
    .elemSizeSel(elemSizeSel), .elemCount(elemCount), .frameCount(frameCount),
    .elemIdx(elemIdx), .frameIdx(frameIdx), .startAddr(startAddr),
    .windowSize(windowSize), .devWrite(devWrite), .addr(addr), .busy(busy),
    .endOfFrame(endOfFrame), .endOfBlock(endOfBlock), .burstSel(burstSel),
    .packEn(packEn), .writeMode(writeMode)
  );

  typedef struct packed {
    logic [1:0]         md;
    logic [1:0]         sz;
    logic [7:0]         eCnt;
    logic [7:0]         fCnt;
    logic signed [15:0] ei;
    logic signed [15:0] fi;
    logic [15:0]        win;
    logic               dev;
    logic [31:0]        base;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd2, 8'd3,  8'd2, 16'sd0, 16'sd0,   16'd0,  1'b0, 32'h0000_1000},
    '{2'd1, 2'd0, 8'd4,  8'd2, 16'sd0, 16'sd0,   16'd0,  1'b0, 32'h0000_2000},
    '{2'd2, 2'd0, 8'd8,  8'd3, 16'sd1, -16'sd7,  16'd8,  1'b1, 32'h4000_0010},
    '{2'd2, 2'd2, 8'd16, 8'd2, 16'sd1, -16'sd63, 16'd64, 1'b1, 32'h0000_8000},
    '{2'd2, 2'd1, 8'd2,  8'd3, 16'sd3, -16'sd9,  16'd48, 1'b0, 32'h0000_0002},
    '{2'd3, 2'd0, 8'd2,  8'd2, 16'sd5, 16'sd5,   16'd96, 1'b1, 32'h0000_ABCD}
  };
  string vecReq [NV] = '{"R4", "R5", "R6 R7 R11", "R6 R7 R10", "R7 R10", "R12 R10"};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_cfg(input vec_t v);
    mode        = v.md;
    elemSizeSel = v.sz;
    elemCount   = {8'd0, v.eCnt};
    frameCount  = {8'd0, v.fCnt};
    elemIdx     = v.ei;
    frameIdx    = v.fi;
    windowSize  = v.win;
    devWrite    = v.dev;
    startAddr   = v.base;
  endtask

  function automatic logic [1:0] exp_burst(input logic [15:0] w);
    if (w == 0) return 2'd0;
    if (w % 64 == 0) return 2'd3;
    if (w % 32 == 0) return 2'd2;
    if (w % 16 == 0) return 2'd1;
    return 2'd0;
  endfunction

  task automatic run_vec(input int idx);
    vec_t v = VECS[idx];
    logic [31:0] bytes, sIn, sFr, expA;
    logic [1:0] expB, expW;
    bytes = 32'd1 << v.sz;
    if (v.md == 2'd1) begin
      sIn = bytes; sFr = bytes;
    end else if (v.md == 2'd2) begin
      sIn = bytes + 32'(v.ei) - 32'd1;
      sFr = bytes + 32'(v.fi) - 32'd1;
    end else begin
      sIn = 0; sFr = 0;
    end
    expB = exp_burst(v.win);
    expW = (v.win != 0 && v.dev) ? 2'd2 : 2'd1;
    load_cfg(v);
    start = 1'b1;
    tick();
    start = 1'b0;
    expA = v.base;
    chk(busy === 1'b1, "R2 busy", {31'd0, busy}, 32'd1);
    chk(burstSel === expB && packEn === (expB != 0), "R10 burst", {30'd0, burstSel}, {30'd0, expB});
    chk(writeMode === expW, "R11 wmode", {30'd0, writeMode}, {30'd0, expW});
    for (int f = 0; f < int'(v.fCnt); f++) begin
      for (int e = 0; e < int'(v.eCnt); e++) begin
        bit lastE, lastF;
        lastE = (e == int'(v.eCnt) - 1);
        lastF = (f == int'(v.fCnt) - 1);
        chk(addr === expA, vecReq[idx], addr, expA);
        chk(endOfFrame === lastE && endOfBlock === (lastE && lastF), "R9 flags",
            {30'd0, endOfFrame, endOfBlock}, {30'd0, lastE, lastE && lastF});
        advance = 1'b1;
        tick();
        advance = 1'b0;
        if (lastE && !lastF) expA = expA + sFr;
        else if (!lastE) expA = expA + sIn;
      end
    end
    chk(busy === 1'b0 && addr === expA, "R9 end", addr, expA);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; advance = 1'b0;
    load_cfg(VECS[0]);
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(busy === 1'b0 && endOfFrame === 1'b0 && endOfBlock === 1'b0, "R1 flags", {31'd0, busy}, 32'd0);
    chk(addr === 32'd0, "R1 addr", addr, 32'd0);
    chk(burstSel === 2'd0 && packEn === 1'b0 && writeMode === 2'd1, "R1 cfg",
        {29'd0, burstSel, packEn}, 32'd0);

    // R8 advance while idle is ignored
    advance = 1'b1;
    tick(); tick();
    advance = 1'b0;
    chk(addr === 32'd0 && busy === 1'b0, "R8 idle advance", addr, 32'd0);

    // R3 zero element count from idle
    load_cfg(VECS[1]);
    elemCount = 16'd0;
    start = 1'b1; tick(); start = 1'b0;
    chk(busy === 1'b0 && addr === 32'd0, "R3 zero elem", addr, 32'd0);

    // Vector table walk
    for (int i = 0; i < NV; i++) run_vec(i);

    // R8 advance held low keeps address
    load_cfg(VECS[1]);
    start = 1'b1; tick(); start = 1'b0;
    advance = 1'b1; tick(); advance = 1'b0;
    chk(addr === 32'h2001, "R5 step", addr, 32'h2001);
    tick(); tick(); tick();
    chk(addr === 32'h2001 && busy === 1'b1, "R8 hold", addr, 32'h2001);

    // R13 restart while busy
    load_cfg(VECS[2]);
    start = 1'b1; tick(); start = 1'b0;
    chk(addr === 32'h4000_0010 && busy === 1'b1 && endOfFrame === 1'b0, "R13 restart", addr, 32'h4000_0010);
    chk(burstSel === 2'd0 && writeMode === 2'd2, "R13 cfg", {30'd0, writeMode}, 32'd2);

    // R3 zero frame count while busy aborts
    advance = 1'b1; tick(); advance = 1'b0;
    frameCount = 16'd0;
    start = 1'b1; tick(); start = 1'b0;
    chk(busy === 1'b0 && addr === 32'h4000_0011, "R3 zero frame", addr, 32'h4000_0011);

    // R1 synchronous reset mid-run
    load_cfg(VECS[3]);
    start = 1'b1; tick(); start = 1'b0;
    advance = 1'b1; tick(); advance = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0;
    chk(busy === 1'b0 && addr === 32'd0 && burstSel === 2'd0 && writeMode === 2'd1, "R1 mid reset", addr, 32'd0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule